// File: doc/BRIEF.md
# Atomic Byte Read-Modify-Write Sequencer

This block is the memory-operand engine for a small set of byte instructions. It accepts a 16-bit instruction word together with three register values supplied by the surrounding pipeline: R0, the global base register, and the value of the register named in the instruction's `nnnn` field. It then runs a byte read, an optional byte write, or both, on a simple request/ready bus. When the instruction defines a test result, it reports a new T-bit value.

Two instruction families are handled. The four byte logic forms (test, AND, XOR, OR) address memory at R0 plus the global base and combine the byte with an 8-bit immediate. The test form only reads the byte and sets T. The other three write the combined byte back to the same address. The test-and-set form reads the byte at the address in the named register and sets T when that byte is zero. It then writes the byte back with bit 7 forced high.

For test-and-set, a lock output stays high from the read request until the write is acknowledged. The system arbiter uses it to refuse every other master for that whole span. Every form takes a fixed number of cycles when memory answers with no wait states.

Top module: `byte_rmw_seq`

## Requirements
- R1: Only these instruction words start an operation: upper byte 0xCC (test), 0xCD (AND), 0xCE (XOR), 0xCF (OR), each with the immediate in bits 7:0, and 0x4n1B (test-and-set, `n` any). On any other word, `start` is ignored: busy and the bus request stay low.
- R2: The byte logic forms address memory at (R0 + GBR) modulo 2^ADDR_W. Test-and-set addresses memory at the named register's value, with R0 and GBR having no effect.
- R3: AND, OR and XOR read the byte and then write (byte op immediate) to the same address, exactly one write per operation. They leave `tWe` low.
- R4: The test form performs one read and no write. It pulses `tWe` together with `done`, with `tOut` = 1 exactly when (byte AND immediate) is zero.
- R5: Test-and-set performs one read, then one write of (byte OR 0x80) to the same address. It pulses `tWe` with `done`, with `tOut` = 1 exactly when the byte read was zero.
- R6: With zero-wait memory, busy lasts 3 cycles for each byte logic form and 4 cycles for test-and-set, counted from the cycle after `start` is sampled.
- R7: A bus access is held, with address, write flag and write data unchanged, until `memRdy` is seen. Each wait cycle adds one cycle to the operation.
- R8: `busLock` is high in every cycle from the test-and-set read request through the cycle of its write acknowledge, with no gap (3 + 2×waits cycles). It is never high for the byte logic forms.
- R9: `done` is a single-cycle pulse in the last busy cycle, and busy falls after it. A `start` raised while busy is ignored.
- R10: After reset, `busy`, `done`, `memReq`, `busLock` and `tWe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to run `instr`, sampled while idle |
| instr | input | 16 | Instruction word |
| r0Val | input | ADDR_W | Value of R0 |
| gbrVal | input | ADDR_W | Value of the global base register |
| rnVal | input | ADDR_W | Value of the register named by instr[11:8] |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Final-cycle pulse |
| tWe | output | 1 | T-bit update strobe |
| tOut | output | 1 | New T-bit value, valid with `tWe` |
| memReq | output | 1 | Bus access request |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | ADDR_W | Byte address |
| memWdata | output | 8 | Write data |
| memRdata | input | 8 | Read data, valid with `memRdy` on a read |
| memRdy | input | 1 | Access acknowledge |
| busLock | output | 1 | Hold off other bus masters |

## Verification
The bench builds the block with ADDR_W = 16. At that width, an R0 plus base sum that overflows the address width takes only a few bits of stimulus, so the address wrap of R2 is directly observable. The bench memory model takes a per-test wait count of 0 to 3 cycles. This exercises both the exact zero-wait cycle counts of R6 and the stretched accesses and longer lock windows of R7 and R8.

// File: rtl/byte_rmw_pkg.sv
package byte_rmw_pkg;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_TST  = 3'd1,
    OP_AND  = 3'd2,
    OP_XOR  = 3'd3,
    OP_OR   = 3'd4,
    OP_TAS  = 3'd5
  } opKindT;

  typedef struct packed {
    logic latchCmd;
    logic latchAddr;
    logic latchRead;
  } ctlStrbT;

  localparam logic [4:0] LOGIC_PREFIX = 5'b11001;
  localparam logic [3:0] TAS_HI       = 4'b0100;
  localparam logic [7:0] TAS_LO       = 8'h1B;

  function automatic opKindT decodeOp(input logic [15:0] word);
    opKindT kind;
    kind = OP_NONE;
    if (word[15:11] == LOGIC_PREFIX && word[10]) begin
      unique case (word[9:8])
        2'b00:   kind = OP_TST;
        2'b01:   kind = OP_AND;
        2'b10:   kind = OP_XOR;
        default: kind = OP_OR;
      endcase
    end else if (word[15:12] == TAS_HI && word[7:0] == TAS_LO) begin
      kind = OP_TAS;
    end
    return kind;
  endfunction

endpackage

// File: rtl/byte_rmw_dp.sv
module byte_rmw_dp
  import byte_rmw_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrbT           strb,
  input  logic [15:0]       instr,
  input  logic [ADDR_W-1:0] r0Val,
  input  logic [ADDR_W-1:0] gbrVal,
  input  logic [ADDR_W-1:0] rnVal,
  input  logic [7:0]        memRdata,
  output opKindT            opCur,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  output logic              tOut
);

  localparam int BYTE_W = 8;

  opKindT            opReg;
  logic [BYTE_W-1:0] immReg;
  logic [ADDR_W-1:0] baseA;
  logic [ADDR_W-1:0] baseB;
  logic [ADDR_W-1:0] addrReg;
  logic [BYTE_W-1:0] dataReg;
  opKindT            opNew;

  assign opNew = decodeOp(instr);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opReg   <= OP_NONE;
      immReg  <= '0;
      baseA   <= '0;
      baseB   <= '0;
      addrReg <= '0;
      dataReg <= '0;
    end else begin
      if (strb.latchCmd) begin
        opReg  <= opNew;
        immReg <= instr[BYTE_W-1:0];
        if (opNew == OP_TAS) begin
          baseA <= rnVal;
          baseB <= '0;
        end else begin
          baseA <= r0Val;
          baseB <= gbrVal;
        end
      end
      if (strb.latchAddr) addrReg <= baseA + baseB;
      if (strb.latchRead) dataReg <= memRdata;
    end
  end

  logic [BYTE_W-1:0] resByte;
  always_comb begin
    unique case (opReg)
      OP_AND:  resByte = dataReg & immReg;
      OP_XOR:  resByte = dataReg ^ immReg;
      OP_OR:   resByte = dataReg | immReg;
      OP_TAS:  resByte = dataReg | {1'b1, {(BYTE_W-1){1'b0}}};
      default: resByte = dataReg;
    endcase
  end

  always_comb begin
    unique case (opReg)
      OP_TST:  tOut = ((dataReg & immReg) == '0);
      OP_TAS:  tOut = (dataReg == '0);
      default: tOut = 1'b0;
    endcase
  end

  assign opCur    = opReg;
  assign memAddr  = addrReg;
  assign memWdata = resByte;

  // R5: test-and-set write data always carries the high bit
  p_tas_msb_r5: assert property (@(posedge clk) disable iff (!rstN)
    (opReg == OP_TAS) |-> memWdata[BYTE_W-1]);

endmodule

// File: rtl/byte_rmw_ctl.sv
module byte_rmw_ctl
  import byte_rmw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [15:0] instr,
  input  opKindT      opCur,
  input  logic        memRdy,
  output ctlStrbT     strb,
  output logic        busy,
  output logic        done,
  output logic        tWe,
  output logic        memReq,
  output logic        memWe,
  output logic        busLock
);

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_RD, S_MOD, S_WR, S_EVAL
  } stateT;

  stateT state, stateNxt;
  logic  isTas;

  assign isTas = (opCur == OP_TAS);

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt       = state;
    strb           = '0;
    memReq         = 1'b0;
    memWe          = 1'b0;
    busLock        = 1'b0;
    done           = 1'b0;
    tWe            = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (start && decodeOp(instr) != OP_NONE) begin
          strb.latchCmd = 1'b1;
          stateNxt      = S_ADDR;
        end
      end
      S_ADDR: begin
        strb.latchAddr = 1'b1;
        stateNxt       = S_RD;
      end
      S_RD: begin
        memReq  = 1'b1;
        busLock = isTas;
        if (memRdy) begin
          strb.latchRead = 1'b1;
          if (opCur == OP_TST)  stateNxt = S_EVAL;
          else if (isTas)       stateNxt = S_MOD;
          else                  stateNxt = S_WR;
        end
      end
      S_MOD: begin
        busLock  = 1'b1;
        stateNxt = S_WR;
      end
      S_WR: begin
        memReq  = 1'b1;
        memWe   = 1'b1;
        busLock = isTas;
        if (memRdy) begin
          done     = 1'b1;
          tWe      = isTas;
          stateNxt = S_IDLE;
        end
      end
      S_EVAL: begin
        done     = 1'b1;
        tWe      = 1'b1;
        stateNxt = S_IDLE;
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE);

  // R8: once raised, lock holds until the write is acknowledged
  p_lock_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busLock && !(memReq && memWe && memRdy)) |=> busLock);

  // R8: lock only ever accompanies test-and-set
  p_lock_tas_only_r8: assert property (@(posedge clk) disable iff (!rstN)
    busLock |-> (opCur == OP_TAS && busy));

  // R9: done ends the operation
  p_done_last_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

  // R4: T update only alongside done
  p_twe_done_r4: assert property (@(posedge clk) disable iff (!rstN)
    tWe |-> done);

  // R4: the test form never writes
  p_tst_nowrite_r4: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe) |-> (opCur != OP_TST));

  // R7: a pending access keeps its request and direction
  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memRdy) |=> (memReq && $stable(memWe)));

endmodule

// File: rtl/byte_rmw_seq.sv
module byte_rmw_seq
  import byte_rmw_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [15:0]       instr,
  input  logic [ADDR_W-1:0] r0Val,
  input  logic [ADDR_W-1:0] gbrVal,
  input  logic [ADDR_W-1:0] rnVal,
  output logic              busy,
  output logic              done,
  output logic              tWe,
  output logic              tOut,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  input  logic [7:0]        memRdata,
  input  logic              memRdy,
  output logic              busLock
);

  ctlStrbT strb;
  opKindT  opCur;

  byte_rmw_ctl u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .instr   (instr),
    .opCur   (opCur),
    .memRdy  (memRdy),
    .strb    (strb),
    .busy    (busy),
    .done    (done),
    .tWe     (tWe),
    .memReq  (memReq),
    .memWe   (memWe),
    .busLock (busLock)
  );

  byte_rmw_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .instr    (instr),
    .r0Val    (r0Val),
    .gbrVal   (gbrVal),
    .rnVal    (rnVal),
    .memRdata (memRdata),
    .opCur    (opCur),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .tOut     (tOut)
  );

  // R7: address and write data stay put while an access waits
  p_bus_stable_r7: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memRdy) |=> ($stable(memAddr) && $stable(memWdata)));

  // R3: read and write of one operation hit the same address
  p_same_addr_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && !$past(done)) |-> $stable(memAddr) || $past(!memReq && !memWe && !busLock && opCur != OP_NONE && !$past(busy)));

endmodule

// File: tb/sim_byte_rmw_seq.sv
module sim_byte_rmw_seq;

  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [15:0]   instr = '0;
  logic [AW-1:0] r0Val = '0, gbrVal = '0, rnVal = '0;
  logic          busy, done, tWe, tOut, memReq, memWe, memRdy, busLock;
  logic [AW-1:0] memAddr;
  logic [7:0]    memWdata, memRdata;

  always #5 clk = ~clk;

  byte_rmw_seq #(.ADDR_W(AW)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .instr(instr),
    .r0Val(r0Val), .gbrVal(gbrVal), .rnVal(rnVal),
    .busy(busy), .done(done), .tWe(tWe), .tOut(tOut),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .memRdy(memRdy),
    .busLock(busLock)
  );

  // memory model
  logic [7:0]    mem [256];
  int            waitCfg = 0;
  int            waitCnt = 0;
  int            wrCount = 0;
  int            rdCount = 0;
  logic [AW-1:0] lastWrAddr = '0, lastRdAddr = '0;

  assign memRdy   = memReq && (waitCnt >= waitCfg);
  assign memRdata = mem[memAddr[7:0]];

  always @(posedge clk) begin
    if (memReq && !memRdy) waitCnt <= waitCnt + 1;
    else                   waitCnt <= 0;
    if (memReq && memRdy) begin
      if (memWe) begin
        mem[memAddr[7:0]] <= memWdata;
        wrCount    <= wrCount + 1;
        lastWrAddr <= memAddr;
      end else begin
        rdCount    <= rdCount + 1;
        lastRdAddr <= memAddr;
      end
    end
  end

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // generic operation runner with its own checks
  task automatic runOp(input string tag, input logic [15:0] iw,
                       input logic [AW-1:0] a0, input logic [AW-1:0] ag,
                       input logic [AW-1:0] an, input int waits,
                       input logic [AW-1:0] expAddr, input bit expWrite,
                       input logic [7:0] expByte, input bit expTwe,
                       input bit expT, input int expCycles, input bit isTas);
    int cyc = 0;
    int lockCyc = 0;
    int lockGap = 0;
    int doneCnt = 0;
    int wr0, rd0;
    bit seenRead = 0;
    bit gotTwe = 0;
    bit gotT = 0;
    waitCfg = waits;
    wr0 = wrCount;
    rd0 = rdCount;
    @(negedge clk);
    instr = iw; r0Val = a0; gbrVal = ag; rnVal = an; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 100; k++) begin
      if (busy) cyc++;
      if (busLock) lockCyc++;
      if (memReq && !memWe) seenRead = 1;
      if (isTas && seenRead && !busLock) lockGap++;
      if (done) begin
        doneCnt++;
        gotTwe = tWe;
        gotT   = tOut;
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
    chk(!busy && !done, "R9", {tag, " idle after done"}, busy, 0);
    chk(doneCnt == 1, "R9", {tag, " done seen"}, doneCnt, 1);
    chk(cyc == expCycles, (waits == 0) ? "R6" : "R7", {tag, " busy cycles"}, cyc, expCycles);
    chk(rdCount - rd0 == 1, "R2", {tag, " one read"}, rdCount - rd0, 1);
    chk(lastRdAddr == expAddr, "R2", {tag, " read address"}, lastRdAddr, expAddr);
    chk(wrCount - wr0 == (expWrite ? 1 : 0), expWrite ? "R3" : "R4",
        {tag, " write count"}, wrCount - wr0, expWrite ? 1 : 0);
    if (expWrite)
      chk(lastWrAddr == expAddr, "R3", {tag, " write address"}, lastWrAddr, expAddr);
    chk(mem[expAddr[7:0]] == expByte, isTas ? "R5" : (expWrite ? "R3" : "R4"),
        {tag, " memory byte"}, mem[expAddr[7:0]], expByte);
    chk(gotTwe == expTwe, isTas ? "R5" : "R4", {tag, " tWe"}, gotTwe, expTwe);
    if (expTwe)
      chk(gotT == expT, isTas ? "R5" : "R4", {tag, " T value"}, gotT, expT);
    if (isTas) begin
      chk(lockCyc == 3 + 2 * waits, "R8", {tag, " lock cycles"}, lockCyc, 3 + 2 * waits);
      chk(lockGap == 0, "R8", {tag, " lock gap"}, lockGap, 0);
    end else begin
      chk(lockCyc == 0, "R8", {tag, " no lock"}, lockCyc, 0);
    end
  endtask

  task automatic testReset();
    chk(!busy && !done && !memReq && !busLock && !tWe, "R10", "reset outputs",
        {busy, done, memReq, busLock, tWe}, 0);
  endtask

  task automatic testAnd();
    mem[8'h30] = 8'hF3;
    runOp("AND", 16'hCD3C, 16'h0010, 16'h0020, 16'h7777, 0,
          16'h0030, 1, 8'h30, 0, 0, 3, 0);
  endtask

  task automatic testOrWrap();
    mem[8'h15] = 8'h01;
    runOp("OR wrap", 16'hCF80, 16'hFFF0, 16'h0025, 16'h0000, 2,
          16'h0015, 1, 8'h81, 0, 0, 7, 0);
  endtask

  task automatic testXor();
    mem[8'h40] = 8'hAA;
    runOp("XOR", 16'hCEFF, 16'h0100, 16'hFF40, 16'h0040, 1,
          16'h0040, 1, 8'h55, 0, 0, 5, 0);
  endtask

  task automatic testTst();
    mem[8'h60] = 8'hF0;
    runOp("TST zero", 16'hCC0F, 16'h0060, 16'h0000, 16'h0000, 0,
          16'h0060, 0, 8'hF0, 1, 1, 3, 0);
    runOp("TST nonzero", 16'hCC30, 16'h0020, 16'h0040, 16'h0000, 1,
          16'h0060, 0, 8'hF0, 1, 0, 4, 0);
  endtask

  task automatic testTas();
    mem[8'h50] = 8'h00;
    runOp("TAS zero", 16'h431B, 16'h0011, 16'h0022, 16'h0050, 0,
          16'h0050, 1, 8'h80, 1, 1, 4, 1);
    mem[8'h58] = 8'h12;
    runOp("TAS nonzero", 16'h4F1B, 16'h0000, 16'h0000, 16'h0158, 3,
          16'h0158, 1, 8'h92, 1, 0, 10, 1);
  endtask

  task automatic testIllegal();
    int busyCnt = 0;
    int wr0 = wrCount;
    int rd0 = rdCount;
    @(negedge clk);
    instr = 16'hC930; start = 1'b1;
    @(negedge clk);
    instr = 16'h401A;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 4; k++) begin
      if (busy || memReq) busyCnt++;
      @(negedge clk);
    end
    chk(busyCnt == 0, "R1", "unknown words start nothing", busyCnt, 0);
    chk(wrCount == wr0 && rdCount == rd0, "R1", "no bus traffic on unknown words",
        (wrCount - wr0) + (rdCount - rd0), 0);
  endtask

  task automatic testStartWhileBusy();
    int cyc = 0;
    int wr0 = wrCount;
    mem[8'h70] = 8'h0F;
    mem[8'h71] = 8'h33;
    waitCfg = 0;
    @(negedge clk);
    instr = 16'hCEF0; r0Val = 16'h0070; gbrVal = 16'h0000; start = 1'b1;
    @(negedge clk);
    // keep start high with a different word and base while busy
    instr = 16'hCF44; r0Val = 16'h0071;
    for (int k = 0; k < 20; k++) begin
      if (busy) cyc++;
      if (done) break;
      @(negedge clk);
    end
    start = 1'b0;
    @(negedge clk);
    chk(cyc == 3, "R9", "second start ignored, busy cycles", cyc, 3);
    chk(mem[8'h70] == 8'hFF, "R9", "first op result", mem[8'h70], 8'hFF);
    chk(mem[8'h71] == 8'h33, "R9", "second op never ran", mem[8'h71], 8'h33);
    chk(wrCount - wr0 == 1, "R9", "single write", wrCount - wr0, 1);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testAnd();
    testOrWrap();
    testXor();
    testTst();
    testTas();
    testIllegal();
    testStartWhileBusy();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule